// File: doc/BRIEF.md
# Five-Pin GPIO Port with Peripheral Pin Takeover

This block is a small general-purpose I/O port of five pins that software controls through three byte-wide registers on a simple register bus. The registers are a port register, an output latch and a direction register. Each pin's direction bit chooses whether the pin drives its latch value (bit 0) or floats as an input (bit 1). Pin input values pass through a two-flop synchroniser before software or a peripheral sees them.

Peripherals, such as a serial transmitter or receiver or the address and control lines of a parallel bus, can take over any pin. A peripheral can force a pin to output, and then drive it from its own data signal. It can also force the pin to input. These overrides act only on the pin path. They never change the stored direction bits, so software can safely read, modify and write the direction register while a peripheral holds a pin.

Only the low five bits of the port register map to pins. Its three upper bits are ordinary read/write control bits. Each one drives an enable output for the weak pull-ups of another external-bus port. The latch and direction registers have no storage above bit 4.

Top module: `gpio_port_ovr`

## Requirements
- R1: While reset is held and after it is released, every direction bit is 1, every latch bit is 0, every pull-up enable is 0 and both synchroniser stages are 0, so the direction register reads 0x1F and the latch register reads 0x00.
- R2: Bus address 2 selects the direction register. Where a pin has no override, its direction bit of 1 makes it an input (`pin_oe` low) and a bit of 0 makes it an output (`pin_oe` high). Writing 0x04 leaves pin 2 as an input and makes pins 0, 1, 3 and 4 outputs.
- R3: When `per_force_out[i]` is 1, pin i drives (`pin_oe[i]` = 1) the value `per_dout[i]`, whatever its direction bit and latch are.
- R4: When `per_force_in[i]` is 1 and `per_force_out[i]` is 0, pin i is an input (`pin_oe[i]` = 0), whatever its direction bit is. A forced output takes priority over a forced input.
- R5: Overrides never change the direction register. A read of address 2 always returns the value software last wrote there, in bits 4:0.
- R6: Bits 7:5 of the port register (address 0) can be written and read back. Bit 5+k drives `pullup_en[k]`.
- R7: Bits 7:5 of the latch register (address 1) and the direction register (address 2) always read as 0, and writes to those bits have no effect.
- R8: A write to the port register loads the latch from bits 4:0. A write to the latch register loads it too. An unforced output pin drives its latch bit.
- R9: Port register bits 4:0 and `pin_sync` show `pin_in` as it was sampled two rising edges earlier.
- R10: Address 3 reads as 0x00, and writes to it change no state.
- R11: `bus_rdata` depends combinationally on `bus_addr` and the register contents in the same cycle. A write takes effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register select: 0 port, 1 latch, 2 direction |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pin_in | input | 5 | Raw pin input levels |
| pin_out | output | 5 | Pin output values |
| pin_oe | output | 5 | Pin output enables, 1 = drive |
| per_force_out | input | 5 | Peripheral forces the pin to output |
| per_force_in | input | 5 | Peripheral forces the pin to input |
| per_dout | input | 5 | Peripheral output data |
| pin_sync | output | 5 | Synchronised pin input values |
| pullup_en | output | 3 | Pull-up enables for three other ports |

## Verification
The bench builds the block with its default widths: five pins, an eight-bit data bus and a two-bit address. With these widths all three pull-up control bits exist, and the unmapped fourth address can be reached. Directed writes cover the 0x04 direction example, all-ones writes to every register (which show the unimplemented upper bits) and conflicting force-in and force-out requests. A long random phase then mixes overrides and bus writes, and a reference model checks the outputs after every clock.

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr #(
  parameter int NPIN = 5,
  parameter int DW   = 8,
  parameter int AW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  input  logic [NPIN-1:0] per_force_out,
  input  logic [NPIN-1:0] per_force_in,
  input  logic [NPIN-1:0] per_dout,
  output logic [NPIN-1:0] pin_sync,
  output logic [DW-NPIN-1:0] pullup_en
);
  localparam int NPU = DW - NPIN;
  localparam logic [AW-1:0] A_PORT = AW'(0);
  localparam logic [AW-1:0] A_LAT  = AW'(1);
  localparam logic [AW-1:0] A_DIR  = AW'(2);

  logic [NPIN-1:0] dir_q, lat_q, s1_q, s2_q;
  logic [NPU-1:0]  pu_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
      pu_q  <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
      if (bus_we) begin
        case (bus_addr)
          A_PORT: begin
            lat_q <= bus_wdata[NPIN-1:0];
            pu_q  <= bus_wdata[DW-1:NPIN];
          end
          A_LAT:   lat_q <= bus_wdata[NPIN-1:0];
          A_DIR:   dir_q <= bus_wdata[NPIN-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_PORT:  bus_rdata = {pu_q, s2_q};
      A_LAT:   bus_rdata = {{NPU{1'b0}}, lat_q};
      A_DIR:   bus_rdata = {{NPU{1'b0}}, dir_q};
      default: bus_rdata = '0;
    endcase
  end

  assign pin_oe    = per_force_out | (~per_force_in & ~dir_q);
  assign pin_out   = (per_force_out & per_dout) | (~per_force_out & lat_q);
  assign pin_sync  = s2_q;
  assign pullup_en = pu_q;
endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk #(
  parameter int NPIN = 5,
  parameter int DW   = 8,
  parameter int AW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [DW-1:0]   bus_wdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] per_force_out,
  input logic [NPIN-1:0] per_dout,
  input logic [NPIN-1:0] dir_q,
  input logic [NPIN-1:0] lat_q,
  input logic [DW-NPIN-1:0] pullup_en
);
  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == AW'(2)) |=> $stable(dir_q)); // R5

  AST_PU_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(0)) |=> pullup_en == $past(bus_wdata[DW-1:NPIN])); // R6

  AST_LAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(1)) |=> lat_q == $past(bus_wdata[NPIN-1:0])); // R8

  AST_ADDR3_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(3)) |=> ($stable(lat_q) && $stable(dir_q) && $stable(pullup_en))); // R10

  AST_FORCE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & per_force_out) == per_force_out) &&
    ((pin_out & per_force_out) == (per_dout & per_force_out))); // R3
endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(.NPIN(NPIN), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .per_force_out(per_force_out), .per_dout(per_dout),
  .dir_q(dir_q), .lat_q(lat_q), .pullup_en(pullup_en)
);

// File: tb/sim_gpio_port_ovr.sv
module sim_gpio_port_ovr;
  localparam int TCK = 10;

  logic       clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic       bus_we = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [4:0] pin_in = 0, pin_out, pin_oe, fo = 0, fi = 0, pdo = 0, pin_sync;
  logic [2:0] pullup_en;

  int checks = 0, errors = 0;
  bit done = 0;

  bit [4:0] m_dir = 5'h1F, m_lat = 0, m_s1 = 0, m_s2 = 0;
  bit [2:0] m_pu = 0;

  gpio_port_ovr u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .per_force_out(fo),
    .per_force_in(fi), .per_dout(pdo), .pin_sync(pin_sync),
    .pullup_en(pullup_en)
  );

  always #(TCK/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 5'h1F; m_lat = 0; m_pu = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (bus_we) begin
        if (bus_addr == 0) begin m_lat = bus_wdata[4:0]; m_pu = bus_wdata[7:5]; end
        else if (bus_addr == 1) m_lat = bus_wdata[4:0];
        else if (bus_addr == 2) m_dir = bus_wdata[4:0];
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      0: return {m_pu, m_s2};
      1: return {3'b0, m_lat};
      2: return {3'b0, m_dir};
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [4:0] eo, ev;
      for (int i = 0; i < 5; i++) begin
        eo[i] = fo[i] ? 1'b1 : (fi[i] ? 1'b0 : !m_dir[i]);
        ev[i] = fo[i] ? pdo[i] : m_lat[i];
      end
      chk("R2/R3/R4 pin_oe", pin_oe, eo);
      chk("R3/R8 pin_out", pin_out, ev);
      chk("R9 pin_sync", pin_sync, m_s2);
      chk("R6 pullup_en", pullup_en, m_pu);
      chk("R5/R7/R10/R11 bus_rdata", bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic cyc(input int a, input bit we, input int d);
    @(posedge clk); #1;
    bus_addr = 2'(a); bus_we = we; bus_wdata = 8'(d);
  endtask

  initial begin
    #(TCK*100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(TCK*2 + 1);
    bus_addr = 2; #1;
    chk("R1 dir reset", bus_rdata, 8'h1F);
    bus_addr = 1; #1;
    chk("R1 latch reset", bus_rdata, 8'h00);
    chk("R1 pullup reset", pullup_en, 0);
    chk("R1 oe reset", pin_oe, 0);
    @(posedge clk); #1; rst_n = 1;
    cyc(2, 1, 8'h04);
    cyc(2, 0, 0);
    #1 chk("R2 oe after 0x04", pin_oe, 5'b11011);
    cyc(1, 1, 8'hFF);
    cyc(1, 0, 0);
    #1 chk("R7 latch upper bits", bus_rdata, 8'h1F);
    cyc(2, 1, 8'hFF);
    cyc(2, 0, 0);
    #1 chk("R7 dir upper bits", bus_rdata, 8'h1F);
    cyc(0, 1, 8'hA0);
    cyc(0, 0, 0);
    #1 chk("R6 pullups", pullup_en, 3'b101);
    cyc(1, 0, 0);
    #1 chk("R8 port write clears latch", bus_rdata, 8'h00);
    cyc(3, 1, 8'hFF);
    cyc(3, 0, 0);
    #1 chk("R10 addr3 read", bus_rdata, 0);
    cyc(1, 0, 0);
    #1 chk("R10 latch kept", bus_rdata, 8'h00);
    cyc(2, 1, 8'h00);
    fo = 5'b00101; fi = 5'b00111; pdo = 5'b00100;
    cyc(2, 0, 0);
    #1 chk("R4 force in", pin_oe, 5'b11101);
    chk("R3 force out data", pin_out, 5'b00100);
    chk("R5 dir unchanged", bus_rdata, 8'h00);
    fo = 0; fi = 0;
    pin_in = 5'h15;
    cyc(0, 0, 0); cyc(0, 0, 0);
    #1 chk("R9 port sync", bus_rdata[4:0], 5'h15);
    for (int n = 0; n < 3000; n++) begin
      pin_in = 5'($urandom); fo = 5'($urandom); fi = 5'($urandom); pdo = 5'($urandom);
      cyc(int'($urandom % 4), ($urandom % 3) == 0, int'($urandom % 256));
    end
    @(posedge clk); #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule